// File: doc/BRIEF.md
# Processor Idle-State Controller

This block runs the two idle conditions of a small processor core: a halt, where execution stops until an interrupt or reset arrives, and a wait, where execution stalls while an active-low test line is polled. A halt command makes the block drive a halt code on its three status lines and, after a configurable delay, a single address-latch strobe so external logic can capture that code. A wait command sends no strobe and no bus activity. The controller holds in the wait until the synchronised test line reads low, or until an interrupt is taken.

A bus hold request is granted one cycle after it appears. While the grant is active the output enable is low and the outputs count as floating. A hold never ends a halt. When it is released during a halt, the strobe is sent again together with the halt code. Interrupts and the test line are acted on only while the block owns the bus. A request that arrives during a grant is taken once the bus comes back.

Top module: `idle_ctl`

## Requirements
- R1: While `reset` is high and in the first cycle after it, `status` equals the passive code, and `ale`, `hlda`, `resume` and `int_take` are 0 while `out_en` is 1.
- R2: `status` is {memory/IO select, data direction, status-0}. The halt code (default 3'b011) is shown in every cycle of a halt, including while a grant is active. The passive code (default 3'b111) is shown otherwise. A halt command raised together with a wait command starts a halt.
- R3: After a halt command is sampled, `ale` stays low for ALE_DELAY cycles. It then goes high for exactly one cycle.
- R4: `hlda` follows `hold` one cycle later and `out_en` is its inverse. `ale` is never high while `hlda` is high.
- R5: A hold granted during a halt keeps the halt. In the first cycle after `hlda` falls, `ale` pulses once with the halt code on `status`.
- R6: A halt ends when `intr` is high with `int_en` high, or when `nmi` has risen. In the cycle after the interrupt is recognised, `int_take` is high for one cycle and `status` shows the passive code.
- R7: `intr` with `int_en` low has no effect. An `nmi` held high after its rising edge was taken does not end a later halt.
- R8: During a wait, `ale` stays low and `status` stays passive. `resume` pulses once, SYNC_STAGES+1 cycles after `test_n` is driven low.
- R9: While `hold` or `hlda` is high, neither `int_take` nor `resume` is raised. A request that is pending when the hold ends in a wait is taken, with `int_take` high, two cycles after `hold` falls. An interrupt takes priority over the test line.
- R10: `reset` ends a halt, and `status` becomes the passive code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| reset | input | 1 | Synchronous reset, active high |
| halt_cmd | input | 1 | Request to enter halt |
| wait_cmd | input | 1 | Request to enter wait |
| test_n | input | 1 | Active-low test line polled during wait |
| intr | input | 1 | Maskable interrupt request, level |
| int_en | input | 1 | Interrupt enable flag |
| nmi | input | 1 | Non-maskable interrupt, rising edge |
| hold | input | 1 | Bus hold request |
| status | output | STAT_W | Status code {mio, dtr, s0} |
| ale | output | 1 | Address-latch strobe |
| hlda | output | 1 | Hold grant |
| out_en | output | 1 | Output enable, low while the grant is active |
| resume | output | 1 | One-cycle pulse when a wait ends on the test line |
| int_take | output | 1 | One-cycle pulse when an interrupt ends an idle state |

## Verification
Counting from the clock edge that samples a stimulus, each result has a fixed due cycle. `status` and `hlda` change one cycle later. `ale` comes ALE_DELAY+1 cycles after a halt command, and one cycle after a hold drops during a halt. `int_take` comes one cycle after recognition. `resume` comes SYNC_STAGES+1 cycles after `test_n` falls. A request held back by a grant appears two cycles after `hold` falls. The bench drives and samples only on falling edges. It computes each due cycle from its own copies of ALE_DELAY and SYNC_STAGES, and it checks both the due cycle and the cycles before it, so an early result fails in the same way as a late one.

// File: rtl/idle_pkg.sv
package idle_pkg;

   typedef enum logic [2:0] {
      ST_RUN   = 3'd0,
      ST_HDLY  = 3'd1,
      ST_HALE  = 3'd2,
      ST_HALT  = 3'd3,
      ST_HHOLD = 3'd4,
      ST_WAIT  = 3'd5
   } idle_st_e;

   function automatic logic is_halt(input idle_st_e s);
      return (s == ST_HDLY) || (s == ST_HALE) || (s == ST_HALT) || (s == ST_HHOLD);
   endfunction

endpackage

// File: rtl/idle_sync.sv
module idle_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic reset,
   input  logic d,
   output logic q
);

   if (STAGES < 0) begin : g_bad_stages
      $error("idle_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_thru
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk) begin
         if (reset) begin
            sr <= {STAGES{RST_VAL}};
         end else begin
            sr[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
               sr[i] <= sr[i-1];
            end
         end
      end
      assign q = sr[STAGES-1];
   end

endmodule

// File: rtl/idle_irq.sv
module idle_irq (
   input  logic clk,
   input  logic reset,
   input  logic nmi,
   input  logic intr,
   input  logic int_en,
   input  logic take,
   output logic irq_req
);

   logic nmi_d;
   logic nmi_pend;
   logic nmi_edge;

   assign nmi_edge = nmi & ~nmi_d;
   assign irq_req  = nmi_pend | nmi_edge | (intr & int_en);

   always_ff @(posedge clk) begin
      if (reset) begin
         nmi_d    <= 1'b0;
         nmi_pend <= 1'b0;
      end else begin
         nmi_d    <= nmi;
         nmi_pend <= (nmi_pend | nmi_edge) & ~take;
      end
   end

   AST_NMI_KEPT: assert property (@(posedge clk) disable iff (reset)
      (nmi_pend && !take) |=> nmi_pend); // R7

endmodule

// File: rtl/idle_fsm.sv
module idle_fsm
   import idle_pkg::*;
#(
   parameter int               ALE_DELAY    = 1,
   parameter int               STAT_W       = 3,
   parameter logic [STAT_W-1:0] HALT_CODE    = 3'b011,
   parameter logic [STAT_W-1:0] PASSIVE_CODE = 3'b111
) (
   input  logic              clk,
   input  logic              reset,
   input  logic              halt_cmd,
   input  logic              wait_cmd,
   input  logic              hold,
   input  logic              hlda,
   input  logic              test_s,
   input  logic              irq_req,
   output logic              take,
   output logic [STAT_W-1:0] status,
   output logic              ale,
   output logic              int_take,
   output logic              resume
);

   localparam int CNT_W = (ALE_DELAY > 1) ? $clog2(ALE_DELAY) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ALE_DELAY - 1);

   if (ALE_DELAY < 1) begin : g_bad_delay
      $error("idle_fsm: ALE_DELAY must be at least 1");
   end
   if (HALT_CODE == PASSIVE_CODE) begin : g_bad_codes
      $error("idle_fsm: halt and passive codes must differ");
   end

   idle_st_e         st, st_n;
   logic [CNT_W-1:0] cnt, cnt_n;
   logic             bus_ok;
   logic             res_c;

   always_comb begin
      st_n   = st;
      cnt_n  = cnt;
      bus_ok = ~hlda & ~hold;
      take   = (st != ST_RUN) && bus_ok && irq_req;
      res_c  = (st == ST_WAIT) && bus_ok && !irq_req && !test_s;
      unique case (st)
         ST_RUN: begin
            if (halt_cmd) begin
               st_n  = ST_HDLY;
               cnt_n = '0;
            end else if (wait_cmd) begin
               st_n = ST_WAIT;
            end
         end
         ST_HDLY, ST_HALE, ST_HALT: begin
            if (hold) begin
               st_n = ST_HHOLD;
            end else if (take) begin
               st_n = ST_RUN;
            end else if (st == ST_HDLY) begin
               if (cnt == CNT_LAST) st_n = ST_HALE;
               else                 cnt_n = cnt + 1'b1;
            end else begin
               st_n = ST_HALT;
            end
         end
         ST_HHOLD: begin
            if (!hold) st_n = ST_HALE;
         end
         ST_WAIT: begin
            if (take || res_c) st_n = ST_RUN;
         end
         default: st_n = ST_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (reset) begin
         st       <= ST_RUN;
         cnt      <= '0;
         int_take <= 1'b0;
         resume   <= 1'b0;
      end else begin
         st       <= st_n;
         cnt      <= cnt_n;
         int_take <= take;
         resume   <= res_c;
      end
   end

   assign status = is_halt(st) ? HALT_CODE : PASSIVE_CODE;
   assign ale    = (st == ST_HALE);

   AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (reset)
      ale |=> !ale); // R3

   AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (reset)
      $past(st == ST_WAIT) && (st == ST_WAIT) |-> (status == PASSIVE_CODE) && !ale); // R8

endmodule

// File: rtl/idle_ctl.sv
module idle_ctl #(
   parameter int                ALE_DELAY    = 1,
   parameter int                SYNC_STAGES  = 2,
   parameter int                STAT_W       = 3,
   parameter logic [STAT_W-1:0] HALT_CODE    = 3'b011,
   parameter logic [STAT_W-1:0] PASSIVE_CODE = 3'b111
) (
   input  logic              clk,
   input  logic              reset,
   input  logic              halt_cmd,
   input  logic              wait_cmd,
   input  logic              test_n,
   input  logic              intr,
   input  logic              int_en,
   input  logic              nmi,
   input  logic              hold,
   output logic [STAT_W-1:0] status,
   output logic              ale,
   output logic              hlda,
   output logic              out_en,
   output logic              resume,
   output logic              int_take
);

   if (STAT_W != 3) begin : g_bad_width
      $error("idle_ctl: status carries exactly three lines");
   end

   logic hlda_q;
   logic test_s;
   logic irq_req;
   logic take;

   always_ff @(posedge clk) begin
      if (reset) hlda_q <= 1'b0;
      else       hlda_q <= hold;
   end

   assign hlda   = hlda_q;
   assign out_en = ~hlda_q;

   idle_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) test_sync_i (
      .clk   (clk),
      .reset (reset),
      .d     (test_n),
      .q     (test_s)
   );

   idle_irq irq_i (
      .clk     (clk),
      .reset   (reset),
      .nmi     (nmi),
      .intr    (intr),
      .int_en  (int_en),
      .take    (take),
      .irq_req (irq_req)
   );

   idle_fsm #(
      .ALE_DELAY    (ALE_DELAY),
      .STAT_W       (STAT_W),
      .HALT_CODE    (HALT_CODE),
      .PASSIVE_CODE (PASSIVE_CODE)
   ) fsm_i (
      .clk      (clk),
      .reset    (reset),
      .halt_cmd (halt_cmd),
      .wait_cmd (wait_cmd),
      .hold     (hold),
      .hlda     (hlda_q),
      .test_s   (test_s),
      .irq_req  (irq_req),
      .take     (take),
      .status   (status),
      .ale      (ale),
      .int_take (int_take),
      .resume   (resume)
   );

   AST_ALE_NOT_IN_HOLD: assert property (@(posedge clk) disable iff (reset)
      hlda |-> !ale); // R4

   AST_TAKE_RESUME_EXCL: assert property (@(posedge clk) disable iff (reset)
      !(int_take && resume)); // R9

   AST_ACT_OWNS_BUS: assert property (@(posedge clk) disable iff (reset)
      (int_take || resume) |-> !hlda); // R9

   AST_TAKE_LEAVES_HALT: assert property (@(posedge clk) disable iff (reset)
      int_take |-> (status == PASSIVE_CODE)); // R6

endmodule

// File: tb/idle_ctl_tb.sv
module idle_ctl_tb_top;

   localparam int         ALE_D  = 2;
   localparam int         SYNC_N = 2;
   localparam logic [2:0] HALTC  = 3'b011;
   localparam logic [2:0] PASSC  = 3'b111;

   logic       clk = 1'b0;
   logic       reset = 1'b1;
   logic       halt_cmd = 1'b0, wait_cmd = 1'b0, test_n = 1'b1;
   logic       intr = 1'b0, int_en = 1'b0, nmi = 1'b0, hold = 1'b0;
   logic [2:0] status;
   logic       ale, hlda, out_en, resume, int_take;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   idle_ctl #(
      .ALE_DELAY    (ALE_D),
      .SYNC_STAGES  (SYNC_N),
      .STAT_W       (3),
      .HALT_CODE    (HALTC),
      .PASSIVE_CODE (PASSC)
   ) dut_i (
      .clk (clk), .reset (reset), .halt_cmd (halt_cmd), .wait_cmd (wait_cmd),
      .test_n (test_n), .intr (intr), .int_en (int_en), .nmi (nmi), .hold (hold),
      .status (status), .ale (ale), .hlda (hlda), .out_en (out_en),
      .resume (resume), .int_take (int_take)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic nxt();
      @(negedge clk);
   endtask

   task automatic go_halt(input bit with_wait);
      halt_cmd = 1'b1;
      wait_cmd = with_wait;
      nxt();
      halt_cmd = 1'b0;
      wait_cmd = 1'b0;
      for (int i = 0; i < ALE_D; i++) begin
         chk("R3 ale held back", 32'(ale), 0);
         chk("R2 halt status", 32'(status), 32'(HALTC));
         nxt();
      end
      chk("R3 ale pulse", 32'(ale), 1);
      nxt();
      chk("R3 ale single", 32'(ale), 0);
      chk("R2 halt kept", 32'(status), 32'(HALTC));
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (3) nxt();
      chk("R1 status in reset", 32'(status), 32'(PASSC));
      reset = 1'b0;
      nxt();
      chk("R1 status", 32'(status), 32'(PASSC));
      chk("R1 ale", 32'(ale), 0);
      chk("R1 hlda", 32'(hlda), 0);
      chk("R1 out_en", 32'(out_en), 1);
      chk("R1 resume", 32'(resume), 0);
      chk("R1 int_take", 32'(int_take), 0);

      // R4 grant while running
      hold = 1'b1;
      nxt();
      chk("R4 hlda up", 32'(hlda), 1);
      chk("R4 out_en low", 32'(out_en), 0);
      hold = 1'b0;
      nxt();
      chk("R4 hlda down", 32'(hlda), 0);
      chk("R4 out_en high", 32'(out_en), 1);

      // R2 halt wins over wait, R7 masked intr ignored
      go_halt(1'b1);
      intr = 1'b1;
      int_en = 1'b0;
      for (int i = 0; i < 5; i++) begin
         nxt();
         chk("R7 masked intr", 32'(int_take), 0);
         chk("R7 still halted", 32'(status), 32'(HALTC));
      end
      intr = 1'b0;

      // R5 hold sweep while halted
      for (int d = 1; d <= 4; d++) begin
         hold = 1'b1;
         nxt();
         for (int k = 0; k < d; k++) begin
            chk("R4 hlda in halt", 32'(hlda), 1);
            chk("R4 out_en in halt", 32'(out_en), 0);
            chk("R4 no ale in hold", 32'(ale), 0);
            chk("R5 halt through hold", 32'(status), 32'(HALTC));
            if (k == d - 1) hold = 1'b0;
            nxt();
         end
         chk("R5 hlda released", 32'(hlda), 0);
         chk("R5 ale reissued", 32'(ale), 1);
         chk("R5 halt status reissued", 32'(status), 32'(HALTC));
         nxt();
         chk("R5 ale single", 32'(ale), 0);
      end

      // R9 interrupt during hold in halt, taken after reissue
      hold = 1'b1;
      nxt();
      intr = 1'b1;
      int_en = 1'b1;
      for (int i = 0; i < 3; i++) begin
         nxt();
         chk("R9 no take in hold", 32'(int_take), 0);
      end
      hold = 1'b0;
      nxt();
      chk("R5 ale before take", 32'(ale), 1);
      chk("R9 no take yet", 32'(int_take), 0);
      nxt();
      chk("R6 take after hold", 32'(int_take), 1);
      chk("R6 passive after take", 32'(status), 32'(PASSC));
      intr = 1'b0;
      nxt();
      chk("R6 take single", 32'(int_take), 0);

      // R6 plain intr exit
      go_halt(1'b0);
      intr = 1'b1;
      nxt();
      chk("R6 intr exit", 32'(int_take), 1);
      chk("R6 intr exit status", 32'(status), 32'(PASSC));
      intr = 1'b0;
      int_en = 1'b0;

      // R6 nmi exit with mask off, R7 level nmi ignored afterwards
      go_halt(1'b0);
      nmi = 1'b1;
      nxt();
      chk("R6 nmi exit", 32'(int_take), 1);
      chk("R6 nmi status", 32'(status), 32'(PASSC));
      go_halt(1'b0);
      for (int i = 0; i < 4; i++) begin
         nxt();
         chk("R7 held nmi ignored", 32'(int_take), 0);
      end
      nmi = 1'b0;

      // R10 reset ends halt
      reset = 1'b1;
      nxt();
      reset = 1'b0;
      nxt();
      chk("R10 reset ends halt", 32'(status), 32'(PASSC));

      // R8 wait polls test line, masked intr ignored
      wait_cmd = 1'b1;
      intr = 1'b1;
      nxt();
      wait_cmd = 1'b0;
      for (int i = 0; i < 6; i++) begin
         chk("R8 no ale in wait", 32'(ale), 0);
         chk("R8 passive in wait", 32'(status), 32'(PASSC));
         chk("R8 no resume", 32'(resume), 0);
         nxt();
      end
      test_n = 1'b0;
      for (int i = 0; i < SYNC_N; i++) begin
         nxt();
         chk("R8 resume not early", 32'(resume), 0);
      end
      nxt();
      chk("R8 resume due", 32'(resume), 1);
      nxt();
      chk("R8 resume single", 32'(resume), 0);
      test_n = 1'b1;
      intr = 1'b0;

      // R9 wait with hold, test and interrupt pending
      repeat (SYNC_N + 1) nxt();
      wait_cmd = 1'b1;
      nxt();
      wait_cmd = 1'b0;
      hold = 1'b1;
      nxt();
      test_n = 1'b0;
      intr = 1'b1;
      int_en = 1'b1;
      for (int i = 0; i < SYNC_N + 3; i++) begin
         nxt();
         chk("R9 no resume in hold", 32'(resume), 0);
         chk("R9 no take in hold", 32'(int_take), 0);
         chk("R4 out_en low in wait", 32'(out_en), 0);
      end
      hold = 1'b0;
      nxt();
      chk("R9 hlda down", 32'(hlda), 0);
      chk("R9 take not before bus back", 32'(int_take), 0);
      nxt();
      chk("R9 take after regain", 32'(int_take), 1);
      chk("R9 interrupt over test", 32'(resume), 0);
      intr = 1'b0;
      int_en = 1'b0;
      test_n = 1'b1;
      nxt();

      summary();
      $finish;
   end

endmodule